// File: doc/BRIEF.md
# Serial Flash Boot Probe Sequencer

This block runs once per start request, ahead of any boot read from an external serial flash. It returns the flash to plain single-bit operation and finds out whether a part is there at all and how it is wired. A part may have been left in a quad or continuous-read state by a warm reset of the host. To clear that state, the block first gives a 1 µs low pulse on the shared D3/RESET line while chip select is high. It then sends three reset preambles, each in its own chip-select frame: eight ones clocked on IO0, then the reset-enable opcode 0x66, then the reset opcode 0x99. After a recovery wait it issues the read-ID opcode 0x9F and collects a 24-bit identifier from IO0 and IO1 at the same time.

An identifier that is neither all zeros nor all ones counts as valid. A valid value on IO0 means the input and output pins of the flash share one host line through a resistor (3-pin wiring). A valid value only on IO1 means a separate output line is used (6-pin wiring). If a fuse input is set, the reset pulse is skipped and D2/D3 are never driven, so those pins stay free as ordinary I/O. Every transfer uses SPI mode 0, single-bit, with SCK at half the system clock.

The state machine moves through these states in order: IDLE, PULSE (skipped when the fuse is set), GAP_FF, PRE_FF, GAP_EN, EN_RST, GAP_RST, DO_RST, RECOVER, READ_ID, JUDGE, DONE. The transitions are as follows:
- IDLE/DONE on start goes to PULSE, or to GAP_FF when the fuse is set.
- Each timed state (PULSE, GAP_*, RECOVER) leaves when its timer expires.
- Each frame state (PRE_FF, EN_RST, DO_RST, READ_ID) leaves when the bit engine finishes.
- JUDGE always goes to DONE.

Top module: `flash_probe_seq`

## Requirements
- R1: After reset, cs_n=1, sck=0, io_oe=0000, done=0, present=0.
- R2: With the fuse clear, a start makes io_oe[3]=1 and io_out[3]=0 for exactly PULSE_US×CLK_MHZ cycles (20 by default). cs_n is high throughout, and this happens before the first frame.
- R3: With the fuse set, there is no reset pulse, and io_oe[3] and io_oe[2] stay 0 for the whole run.
- R4: With the fuse clear, io_out[3:2]=11 and io_oe[3:2]=11 hold whenever cs_n is low.
- R5: SPI mode 0 applies. sck is low whenever cs_n is high. IO0 changes only while sck is low. sck runs at half the clock, so each 8-bit frame keeps cs_n low for 17 cycles and the ID frame for 65.
- R6: A run sends exactly four frames, MSB first on IO0, in this order: 0xFF (8 bits), 0x66 (8 bits), 0x99 (8 bits), 0x9F (32 clocks). Between the preamble frames cs_n is high for exactly CS_GAP cycles (2).
- R7: After the 0x99 frame, cs_n stays high for exactly RECOV_US×CLK_MHZ cycles (600) before the ID frame.
- R8: In the ID frame, IO0 is driven only for the 8 opcode bits. io_oe[1] is never set.
- R9: If the 24 bits sampled on IO0 after the opcode are a valid ID, then present=1 and six_pin=0, and dev_id holds that value. An ID is valid when it is neither 0x000000 nor 0xFFFFFF.
- R10: If IO0 is invalid and IO1 is valid, then present=1, six_pin=1, and dev_id holds the IO1 value.
- R11: If neither line is valid, then done=1, present=0, six_pin=0 and dev_id=0. When both lines are valid, IO0 wins.
- R12: A start during a run is ignored. done stays high with cs_n high and sck low until the next start, and a start from DONE begins a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_MHZ) |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted in IDLE or DONE |
| fuse_no_rst | input | 1 | Suppresses the reset pulse and keeps D2/D3 released |
| io_in | input | 4 | Sensed levels of the four flash data lines |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, mode 0 |
| io_out | output | 4 | Drive values for the data lines |
| io_oe | output | 4 | Per-line output enables |
| done | output | 1 | Probe finished |
| present | output | 1 | A valid ID was seen |
| six_pin | output | 1 | 1 = ID came on IO1 (6-pin), 0 = on IO0 (3-pin) |
| dev_id | output | 24 | Captured identifier |

## Verification
The bound checker covers the rules that hold on every cycle:
- the reset pulse appears only while chip select is high;
- D2/D3 stay released under the fuse;
- SCK never toggles outside a frame and never stays high for two cycles;
- IO0 changes only while SCK is low;
- present is never reported before done, and done means an idle bus.

The directed scenarios cover what needs a whole run. They check frame order and opcodes, exact gap and recovery lengths, and the pulse width. They also check the wiring decision for a 3-pin part, a 6-pin part, no part, a part whose ID line is stuck low, and a case with both lines valid. Finally they confirm that a start issued mid-run is ignored.

// File: rtl/fpb_pkg.sv
package fpb_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PULSE,
        S_GAP_FF,
        S_PRE_FF,
        S_GAP_EN,
        S_EN_RST,
        S_GAP_RST,
        S_DO_RST,
        S_RECOVER,
        S_READ_ID,
        S_JUDGE,
        S_DONE
    } seq_state_t;

    localparam logic [7:0] OP_RELEASE = 8'hFF;
    localparam logic [7:0] OP_RST_EN  = 8'h66;
    localparam logic [7:0] OP_RST     = 8'h99;
    localparam logic [7:0] OP_ID      = 8'h9F;

endpackage

// File: rtl/fpb_timer.sv
module fpb_timer #(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/fpb_bit_engine.sv
module fpb_bit_engine #(
    parameter int XW  = 32,
    parameter int RXW = 24,
    parameter int LW  = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [XW-1:0]  tx_word,
    input  logic [LW-1:0]  n_bits,
    input  logic [LW-1:0]  n_drive,
    input  logic [1:0]     sdi,
    output logic           sck,
    output logic           mosi,
    output logic           mosi_oe,
    output logic           fin,
    output logic [RXW-1:0] rx_io0,
    output logic [RXW-1:0] rx_io1
);
    logic          active;
    logic          phase;
    logic [XW-1:0] sr;
    logic [LW-1:0] sent;
    logic [LW-1:0] total;
    logic [LW-1:0] drive;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            phase  <= 1'b0;
            sck    <= 1'b0;
            fin    <= 1'b0;
            sr     <= '0;
            sent   <= '0;
            total  <= '0;
            drive  <= '0;
            rx_io0 <= '0;
            rx_io1 <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                active <= 1'b1;
                phase  <= 1'b0;
                sck    <= 1'b0;
                sr     <= tx_word;
                sent   <= '0;
                total  <= n_bits;
                drive  <= n_drive;
            end else if (active) begin
                if (!phase) begin
                    // rising SCK: sample both candidate data-out lines
                    sck    <= 1'b1;
                    phase  <= 1'b1;
                    rx_io0 <= {rx_io0[RXW-2:0], sdi[0]};
                    rx_io1 <= {rx_io1[RXW-2:0], sdi[1]};
                end else begin
                    // falling SCK: present the next output bit
                    sck   <= 1'b0;
                    phase <= 1'b0;
                    sr    <= {sr[XW-2:0], 1'b0};
                    sent  <= sent + LW'(1);
                    if (sent + LW'(1) == total) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                    end
                end
            end
        end
    end

    assign mosi    = sr[XW-1];
    assign mosi_oe = active && (sent < drive);
endmodule

// File: rtl/fpb_id_judge.sv
module fpb_id_judge #(
    parameter int IDW = 24
) (
    input  logic [IDW-1:0] id_io0,
    input  logic [IDW-1:0] id_io1,
    output logic           found,
    output logic           on_io1,
    output logic [IDW-1:0] id_pick
);
    logic ok0, ok1;

    always_comb begin
        ok0     = (|id_io0) && !(&id_io0);
        ok1     = (|id_io1) && !(&id_io1);
        found   = ok0 || ok1;
        on_io1  = !ok0 && ok1;
        if (ok0) begin
            id_pick = id_io0;
        end else if (ok1) begin
            id_pick = id_io1;
        end else begin
            id_pick = '0;
        end
    end
endmodule

// File: rtl/flash_probe_seq.sv
module flash_probe_seq
    import fpb_pkg::*;
#(
    parameter int CLK_MHZ  = 20,
    parameter int PULSE_US = 1,
    parameter int RECOV_US = 30,
    parameter int CS_GAP   = 2,
    parameter int ID_BITS  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               fuse_no_rst,
    input  logic [3:0]         io_in,
    output logic               cs_n,
    output logic               sck,
    output logic [3:0]         io_out,
    output logic [3:0]         io_oe,
    output logic               done,
    output logic               present,
    output logic               six_pin,
    output logic [ID_BITS-1:0] dev_id
);
    localparam int OPC_BITS  = 8;
    localparam int XW        = OPC_BITS + ID_BITS;
    localparam int LW        = $clog2(XW + 1);
    localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
    localparam int RECOV_CYC = CLK_MHZ * RECOV_US;
    localparam int TMAX_A    = (PULSE_CYC > CS_GAP) ? PULSE_CYC : CS_GAP;
    localparam int TMAX      = (RECOV_CYC > TMAX_A) ? RECOV_CYC : TMAX_A;
    localparam int TW        = $clog2(TMAX + 1);

    seq_state_t state, nxt;

    logic               tmr_load;
    logic [TW-1:0]      tmr_val;
    logic               tmr_exp;
    logic               go;
    logic [XW-1:0]      tx_word;
    logic [LW-1:0]      n_bits;
    logic [LW-1:0]      n_drive;
    logic               mosi, mosi_oe, fin;
    logic [ID_BITS-1:0] rx0, rx1;
    logic               j_found, j_io1;
    logic [ID_BITS-1:0] j_id;
    logic               in_frame;
    logic               accept;

    fpb_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    fpb_bit_engine #(.XW(XW), .RXW(ID_BITS), .LW(LW)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .tx_word (tx_word),
        .n_bits  (n_bits),
        .n_drive (n_drive),
        .sdi     (io_in[1:0]),
        .sck     (sck),
        .mosi    (mosi),
        .mosi_oe (mosi_oe),
        .fin     (fin),
        .rx_io0  (rx0),
        .rx_io1  (rx1)
    );

    fpb_id_judge #(.IDW(ID_BITS)) u_judge (
        .id_io0  (rx0),
        .id_io1  (rx1),
        .found   (j_found),
        .on_io1  (j_io1),
        .id_pick (j_id)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions, timer loads and frame launches
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        go       = 1'b0;
        tx_word  = '0;
        n_bits   = LW'(OPC_BITS);
        n_drive  = LW'(OPC_BITS);
        accept   = 1'b0;
        unique case (state)
            S_IDLE, S_DONE: begin
                if (start) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (fuse_no_rst) begin
                        nxt     = S_GAP_FF;
                        tmr_val = TW'(CS_GAP - 1);
                    end else begin
                        nxt     = S_PULSE;
                        tmr_val = TW'(PULSE_CYC - 1);
                    end
                end
            end
            S_PULSE: begin
                if (tmr_exp) begin
                    nxt      = S_GAP_FF;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CS_GAP - 1);
                end
            end
            S_GAP_FF: begin
                if (tmr_exp) begin
                    nxt     = S_PRE_FF;
                    go      = 1'b1;
                    tx_word = {OP_RELEASE, {ID_BITS{1'b0}}};
                end
            end
            S_PRE_FF: begin
                if (fin) begin
                    nxt      = S_GAP_EN;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CS_GAP - 1);
                end
            end
            S_GAP_EN: begin
                if (tmr_exp) begin
                    nxt     = S_EN_RST;
                    go      = 1'b1;
                    tx_word = {OP_RST_EN, {ID_BITS{1'b0}}};
                end
            end
            S_EN_RST: begin
                if (fin) begin
                    nxt      = S_GAP_RST;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CS_GAP - 1);
                end
            end
            S_GAP_RST: begin
                if (tmr_exp) begin
                    nxt     = S_DO_RST;
                    go      = 1'b1;
                    tx_word = {OP_RST, {ID_BITS{1'b0}}};
                end
            end
            S_DO_RST: begin
                if (fin) begin
                    nxt      = S_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RECOV_CYC - 1);
                end
            end
            S_RECOVER: begin
                if (tmr_exp) begin
                    nxt     = S_READ_ID;
                    go      = 1'b1;
                    tx_word = {OP_ID, {ID_BITS{1'b0}}};
                    n_bits  = LW'(XW);
                end
            end
            S_READ_ID: begin
                if (fin) begin
                    nxt = S_JUDGE;
                end
            end
            S_JUDGE: begin
                nxt = S_DONE;
            end
            default: begin
                nxt = S_IDLE;
            end
        endcase
    end

    // pin outputs
    always_comb begin
        in_frame = (state == S_PRE_FF) || (state == S_EN_RST) ||
                   (state == S_DO_RST) || (state == S_READ_ID);
        cs_n      = !in_frame;
        done      = (state == S_DONE);
        io_out[0] = mosi;
        io_oe[0]  = in_frame && mosi_oe;
        io_out[1] = 1'b0;
        io_oe[1]  = 1'b0;
        io_out[2] = 1'b1;
        io_oe[2]  = !fuse_no_rst && in_frame;
        io_out[3] = (state != S_PULSE);
        io_oe[3]  = !fuse_no_rst && (in_frame || (state == S_PULSE));
    end

    // probe result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            present <= 1'b0;
            six_pin <= 1'b0;
            dev_id  <= '0;
        end else if (accept) begin
            present <= 1'b0;
            six_pin <= 1'b0;
            dev_id  <= '0;
        end else if (state == S_JUDGE) begin
            present <= j_found;
            six_pin <= j_io1;
            dev_id  <= j_id;
        end
    end
endmodule

// File: rtl/fpb_checker.sv
module fpb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       fuse_no_rst,
    input logic       cs_n,
    input logic       sck,
    input logic [3:0] io_out,
    input logic [3:0] io_oe,
    input logic       done,
    input logic       present
);
    assert_pulse_cs_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe[3] && !io_out[3]) |-> cs_n);

    assert_fuse_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_no_rst |-> (io_oe[3:2] == 2'b00));

    assert_sck_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    assert_sck_half_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sck |=> !sck);

    assert_mosi_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$stable(io_out[0])) |-> !sck);

    assert_present_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        present |-> done);

    assert_done_idle_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !sck));
endmodule

bind flash_probe_seq fpb_checker u_fpb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fuse_no_rst (fuse_no_rst),
    .cs_n        (cs_n),
    .sck         (sck),
    .io_out      (io_out),
    .io_oe       (io_oe),
    .done        (done),
    .present     (present)
);

// File: tb/sim_flash_probe_seq.sv
module sim_flash_probe_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fuse = 1'b0;
    logic [3:0]  io_in;
    logic        cs_n, sck, done, present, six_pin;
    logic [3:0]  io_out, io_oe;
    logic [23:0] dev_id;

    int n_chk = 0;
    int n_fail = 0;

    // flash model controls
    logic        drv0_en = 1'b0, drv1_en = 1'b0;
    logic [23:0] id0_val = '0, id1_val = '0;

    // monitor state
    int          frames, pulse_cyc, cs_hi_run, bitcnt, oe0cnt, lowcnt;
    int          fr_bits [0:7];
    int          fr_gap  [0:7];
    int          fr_oe0  [0:7];
    int          fr_len  [0:7];
    logic [7:0]  fr_op   [0:7];
    logic [7:0]  cmd;
    logic [31:0] shreg;
    bit          pulse_late, fuse_drv_seen, io1_drv;
    int          hold_bad;
    logic        prev_sck, prev_cs;

    always #10 clk = ~clk;

    flash_probe_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .fuse_no_rst(fuse),
        .io_in(io_in), .cs_n(cs_n), .sck(sck), .io_out(io_out), .io_oe(io_oe),
        .done(done), .present(present), .six_pin(six_pin), .dev_id(dev_id)
    );

    logic flash_talk;
    logic [4:0] bit_ix;
    assign flash_talk = !cs_n && (cmd == 8'h9F) && (bitcnt >= 8) && (bitcnt < 32);
    assign bit_ix     = 5'((31 - bitcnt) & 31);
    assign io_in[0]   = (flash_talk && drv0_en) ? id0_val[bit_ix] : (io_oe[0] ? io_out[0] : 1'b1);
    assign io_in[1]   = (flash_talk && drv1_en) ? id1_val[bit_ix] : 1'b1;
    assign io_in[3:2] = 2'b11;

    task automatic clear_mon();
        frames = 0; pulse_cyc = 0; cs_hi_run = 0; bitcnt = 0; oe0cnt = 0; lowcnt = 0;
        cmd = '0; shreg = '0; pulse_late = 0; fuse_drv_seen = 0; io1_drv = 0; hold_bad = 0;
        for (int i = 0; i < 8; i++) begin
            fr_bits[i] = 0; fr_gap[i] = 0; fr_oe0[i] = 0; fr_len[i] = 0; fr_op[i] = '0;
        end
    endtask

    initial begin
        clear_mon();
        prev_sck = 1'b0;
        prev_cs  = 1'b1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n && prev_cs) begin
                if (frames < 8) fr_gap[frames] = cs_hi_run;
                bitcnt = 0; oe0cnt = 0; lowcnt = 0; cmd = '0;
            end
            if (cs_n) cs_hi_run++; else begin cs_hi_run = 0; lowcnt++; end
            if (!cs_n && sck && !prev_sck) begin
                shreg = {shreg[30:0], io_out[0]};
                if (io_oe[0]) oe0cnt++;
                bitcnt++;
                if (bitcnt == 8) cmd = shreg[7:0];
            end
            if (cs_n && !prev_cs) begin
                if (frames < 8) begin
                    fr_op[frames] = cmd; fr_bits[frames] = bitcnt;
                    fr_oe0[frames] = oe0cnt; fr_len[frames] = lowcnt;
                end
                frames++;
            end
            if (io_oe[3] && !io_out[3]) begin
                pulse_cyc++;
                if (frames > 0 || !cs_n) pulse_late = 1;
            end
            if (fuse && (io_oe[3] || io_oe[2])) fuse_drv_seen = 1;
            if (!cs_n && !fuse && !(io_oe[3:2] == 2'b11 && io_out[3:2] == 2'b11)) hold_bad++;
            if (io_oe[1]) io1_drv = 1;
        end
        prev_sck = sck;
        prev_cs  = cs_n;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk("R12 done reached", 32'(done), 32'd1);
    endtask

    task automatic run_probe(input logic fz);
        fuse = fz;
        clear_mon();
        pulse_start();
        wait_done();
    endtask

    task automatic frame_checks(input logic fz);
        chk("R6 frame count", 32'(frames), 32'd4);
        chk("R6 op0", 32'(fr_op[0]), 32'hFF);
        chk("R6 op1", 32'(fr_op[1]), 32'h66);
        chk("R6 op2", 32'(fr_op[2]), 32'h99);
        chk("R6 op3", 32'(fr_op[3]), 32'h9F);
        chk("R6 bits0", 32'(fr_bits[0]), 32'd8);
        chk("R6 bits3", 32'(fr_bits[3]), 32'd32);
        chk("R6 gap1", 32'(fr_gap[1]), 32'd2);
        chk("R6 gap2", 32'(fr_gap[2]), 32'd2);
        chk("R7 recovery", 32'(fr_gap[3]), 32'd600);
        chk("R5 len byte frame", 32'(fr_len[1]), 32'd17);
        chk("R5 len id frame", 32'(fr_len[3]), 32'd65);
        chk("R8 io0 driven bits", 32'(fr_oe0[3]), 32'd8);
        chk("R8 io1 never driven", 32'(io1_drv), 32'd0);
        if (fz) begin
            chk("R3 no pulse", 32'(pulse_cyc), 32'd0);
            chk("R3 d2 d3 released", 32'(fuse_drv_seen), 32'd0);
        end else begin
            chk("R2 pulse width", 32'(pulse_cyc), 32'd20);
            chk("R2 pulse before frames", 32'(pulse_late), 32'd0);
            chk("R4 d2 d3 high in frames", 32'(hold_bad), 32'd0);
        end
    endtask

    task automatic t_reset();
        chk("R1 cs_n", 32'(cs_n), 32'd1);
        chk("R1 sck", 32'(sck), 32'd0);
        chk("R1 io_oe", 32'(io_oe), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 present", 32'(present), 32'd0);
    endtask

    task automatic t_three_pin();
        drv0_en = 1; drv1_en = 0; id0_val = 24'hEF4015;
        run_probe(1'b0);
        frame_checks(1'b0);
        chk("R9 present", 32'(present), 32'd1);
        chk("R9 wiring", 32'(six_pin), 32'd0);
        chk("R9 id", 32'(dev_id), 32'hEF4015);
    endtask

    task automatic t_six_pin_fused();
        drv0_en = 0; drv1_en = 1; id1_val = 24'hC22817;
        run_probe(1'b1);
        frame_checks(1'b1);
        chk("R10 present", 32'(present), 32'd1);
        chk("R10 wiring", 32'(six_pin), 32'd1);
        chk("R10 id", 32'(dev_id), 32'hC22817);
    endtask

    task automatic t_absent();
        drv0_en = 0; drv1_en = 0;
        run_probe(1'b0);
        chk("R11 absent present", 32'(present), 32'd0);
        chk("R11 absent wiring", 32'(six_pin), 32'd0);
        chk("R11 absent id", 32'(dev_id), 32'd0);
    endtask

    task automatic t_stuck_low();
        drv0_en = 0; drv1_en = 1; id1_val = 24'h000000;
        run_probe(1'b1);
        chk("R11 zero id present", 32'(present), 32'd0);
        chk("R11 zero id done", 32'(done), 32'd1);
    endtask

    task automatic t_both_valid();
        drv0_en = 1; drv1_en = 1; id0_val = 24'h123456; id1_val = 24'h654321;
        run_probe(1'b0);
        chk("R11 io0 priority wiring", 32'(six_pin), 32'd0);
        chk("R11 io0 priority id", 32'(dev_id), 32'h123456);
    endtask

    task automatic t_busy_start();
        drv0_en = 1; drv1_en = 0; id0_val = 24'h00A501;
        fuse = 1'b0;
        clear_mon();
        pulse_start();
        repeat (300) @(posedge clk);
        #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        wait_done();
        chk("R12 no restart frames", 32'(frames), 32'd4);
        chk("R12 single pulse", 32'(pulse_cyc), 32'd20);
        chk("R12 result", 32'(dev_id), 32'h00A501);
        repeat (40) @(negedge clk);
        chk("R12 done held", 32'(done), 32'd1);
        chk("R12 bus idle", 32'({cs_n, sck}), 32'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_three_pin();
        t_six_pin_fused();
        t_absent();
        t_stuck_low();
        t_both_valid();
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule